// File: doc/BRIEF.md
# Interrupt Controller Programming Sequencer

This block is the byte-wide register front end of an eight-input interrupt controller. Software reaches it through two addresses. Address 0 carries the start-of-initialization word and, once the controller is configured, two kinds of command. One kind retires in-service interrupts. The other chooses which status register a read of address 0 returns. Address 1 carries the remaining configuration words during initialization and the interrupt mask register afterwards.

The configuration sequence is conditional. After the vector-base word, the third word is requested only in cascaded mode. The fourth word is requested only when the first word asked for it. The request and in-service registers also take single-cycle set and clear strobes from the surrounding controller logic, which does the priority resolution and vector delivery.

Any write that the current state cannot accept raises a one-cycle error pulse. Such a write changes no state.

Top module: `pic_seq_top`

## Requirements
- R1: After reset the sequencer is in its idle (unconfigured) state. The error pulse is low. The mask, the request, the in-service and all configuration registers are zero, and the read select points at the request register.
- R2: A write to address 0 with bit 4 set stores the byte as configuration word 1 and makes the sequencer wait for word 2, from any state. `initDone` is low from the next cycle.
- R3: A write to address 1 while waiting for word 2 stores it on `vecBase`. The sequencer then waits for word 3 if word 1 bit 1 is 0, else for word 4 if word 1 bit 0 is 1, else it becomes ready. A write to address 1 while waiting for word 3 stores `cascadeCfg` and then waits for word 4 if word 1 bit 0 is 1, else it becomes ready. A write to address 1 while waiting for word 4 stores `modeCfg` and the sequencer becomes ready. `initDone` is high exactly in the ready state.
- R4: A write to address 1 in the idle or ready state loads the mask register (`maskOut`). A read of address 1 always returns the mask. Writes of words 2 to 4 leave the mask unchanged.
- R5: In the ready state, a write to address 0 with bits 4:3 = 01 latches a read select. A read of address 0 returns the request register when the select's bits 1:0 are 10, the in-service register when they are 11, and 0 otherwise.
- R6: In the ready state, a write to address 0 with bits 4:3 = 00 and bits 7:5 = 011 clears the in-service bit whose index is bits 2:0.
- R7: In the ready state, a write to address 0 with bits 4:3 = 00 and bits 7:5 = 001 clears the lowest-numbered set in-service bit. With no bit set, it changes nothing.
- R8: In the ready state, a write to address 0 with bits 4:3 = 00 and bits 7:5 = 010 or 110 is accepted with no effect and no error.
- R9: A write to address 0 with bit 4 clear in any state other than ready raises `cmdError`. So does any value of bits 7:5 not listed in R6 to R8 with bits 4:3 = 00 in the ready state. The rejected write leaves the state and all registers unchanged.
- R10: Each cycle the request register becomes (old AND NOT `reqClr`) OR `reqSet`. The in-service register becomes (old AND NOT the bit retired by R6 or R7) OR `svcSet`. A set therefore wins over a clear of the same bit in the same cycle.
- R11: `cmdError` is a registered pulse. It is high for the single cycle after each rejected write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 1 | Register address (0 or 1) |
| busWrEn | input | 1 | Write strobe for one cycle |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Combinational read data for busAddr |
| reqSet | input | 8 | Per-line request set strobes |
| reqClr | input | 8 | Per-line request clear strobes |
| svcSet | input | 8 | Per-line in-service set strobes |
| cmdError | output | 1 | Pulse: previous write was rejected |
| initDone | output | 1 | Sequencer is in the ready state |
| maskOut | output | 8 | Interrupt mask register |
| vecBase | output | 8 | Configuration word 2 |
| cascadeCfg | output | 8 | Configuration word 3 |
| modeCfg | output | 8 | Configuration word 4 |

## Verification
Two functions can land in the same cycle. One is a bus write that retires an in-service bit (R6 or R7). The other is the external `svcSet` strobe that marks a line in service. The bench pairs an end-of-interrupt write with a `svcSet` on a different bit and then on the same bit, and reads the in-service register back. It expects the retired bit cleared and the newly marked bit kept, with the set winning when both hit one bit. The request register is driven the same way, with `reqSet` and `reqClr` asserted together on one line and on different lines.

// File: rtl/pic_seq_pkg.sv
package pic_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_WAIT2 = 3'd1,
    ST_WAIT3 = 3'd2,
    ST_WAIT4 = 3'd3,
    ST_READY = 3'd4
  } seqState_t;

  // Strobes from control to datapath, one per register action
  typedef struct packed {
    logic ldWord1;
    logic ldWord2;
    logic ldWord3;
    logic ldWord4;
    logic ldMask;
    logic ldSelect;
    logic clrLevel;
    logic clrLowest;
    logic reject;
  } regStrobe_t;

  // Command byte field positions
  localparam int CMD_INIT_BIT  = 4;
  localparam int CMD_SEL_BIT   = 3;
  localparam int CMD_CODE_LSB  = 5;

endpackage

// File: rtl/pic_seq_ctrl.sv
module pic_seq_ctrl
  import pic_seq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busAddr,
  input  logic              busWrEn,
  input  logic [DATA_W-1:0] busWrData,
  input  logic [1:0]        word1Mode,   // {single, needWord4}
  output regStrobe_t        strb,
  output logic              ready,
  output logic              errPulse
);

  seqState_t stateQ, stateD;
  logic      errQ;
  logic [2:0] cmdCode;

  assign cmdCode = busWrData[CMD_CODE_LSB +: 3];

  always_comb begin
    strb   = '0;
    stateD = stateQ;
    if (busWrEn) begin
      if (!busAddr) begin
        if (busWrData[CMD_INIT_BIT]) begin
          strb.ldWord1 = 1'b1;
          stateD       = ST_WAIT2;
        end else if (stateQ == ST_READY) begin
          if (busWrData[CMD_SEL_BIT]) begin
            strb.ldSelect = 1'b1;
          end else begin
            // cmdCode = {rotate, specific, eoi}
            case (cmdCode)
              3'b011:         strb.clrLevel  = 1'b1;
              3'b001:         strb.clrLowest = 1'b1;
              3'b010, 3'b110: ;
              default:        strb.reject    = 1'b1;
            endcase
          end
        end else begin
          strb.reject = 1'b1;
        end
      end else begin
        case (stateQ)
          ST_WAIT2: begin
            strb.ldWord2 = 1'b1;
            if (!word1Mode[1])     stateD = ST_WAIT3;
            else if (word1Mode[0]) stateD = ST_WAIT4;
            else                   stateD = ST_READY;
          end
          ST_WAIT3: begin
            strb.ldWord3 = 1'b1;
            stateD = word1Mode[0] ? ST_WAIT4 : ST_READY;
          end
          ST_WAIT4: begin
            strb.ldWord4 = 1'b1;
            stateD = ST_READY;
          end
          default: strb.ldMask = 1'b1;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      errQ   <= 1'b0;
    end else begin
      stateQ <= stateD;
      errQ   <= strb.reject;
    end
  end

  assign ready    = (stateQ == ST_READY);
  assign errPulse = errQ;

endmodule

// File: rtl/pic_seq_regs.sv
module pic_seq_regs
  import pic_seq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busAddr,
  input  logic [DATA_W-1:0] busWrData,
  input  regStrobe_t        strb,
  input  logic [DATA_W-1:0] reqSet,
  input  logic [DATA_W-1:0] reqClr,
  input  logic [DATA_W-1:0] svcSet,
  output logic [DATA_W-1:0] busRdData,
  output logic [1:0]        word1Mode,
  output logic [DATA_W-1:0] maskOut,
  output logic [DATA_W-1:0] vecBase,
  output logic [DATA_W-1:0] cascadeCfg,
  output logic [DATA_W-1:0] modeCfg
);

  localparam int LVL_W = $clog2(DATA_W);
  localparam logic [DATA_W-1:0] SEL_RESET = DATA_W'(2);

  logic [DATA_W-1:0] word1Q, word2Q, word3Q, word4Q, maskQ, selQ;
  logic [DATA_W-1:0] irrQ, isrQ;
  logic [DATA_W-1:0] retireMask, lowestSet;
  logic [LVL_W-1:0]  level;

  assign level     = busWrData[LVL_W-1:0];
  assign lowestSet = isrQ & (~isrQ + DATA_W'(1));

  always_comb begin
    retireMask = '0;
    if (strb.clrLevel)  retireMask = DATA_W'(1) << level;
    if (strb.clrLowest) retireMask = lowestSet;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      word1Q <= '0;
      word2Q <= '0;
      word3Q <= '0;
      word4Q <= '0;
      maskQ  <= '0;
      selQ   <= SEL_RESET;
    end else begin
      if (strb.ldWord1)  word1Q <= busWrData;
      if (strb.ldWord2)  word2Q <= busWrData;
      if (strb.ldWord3)  word3Q <= busWrData;
      if (strb.ldWord4)  word4Q <= busWrData;
      if (strb.ldMask)   maskQ  <= busWrData;
      if (strb.ldSelect) selQ   <= busWrData;
    end
  end

  // Per-line status flops: set strobes take precedence over clears
  always_ff @(posedge clk) begin
    if (!rstN) begin
      irrQ <= '0;
      isrQ <= '0;
    end else begin
      for (int b = 0; b < DATA_W; b++) begin
        irrQ[b] <= (irrQ[b] & ~reqClr[b])     | reqSet[b];
        isrQ[b] <= (isrQ[b] & ~retireMask[b]) | svcSet[b];
      end
    end
  end

  always_comb begin
    if (busAddr)                 busRdData = maskQ;
    else if (selQ[1:0] == 2'b10) busRdData = irrQ;
    else if (selQ[1:0] == 2'b11) busRdData = isrQ;
    else                         busRdData = '0;
  end

  assign word1Mode  = word1Q[1:0];
  assign maskOut    = maskQ;
  assign vecBase    = word2Q;
  assign cascadeCfg = word3Q;
  assign modeCfg    = word4Q;

endmodule

// File: rtl/pic_seq_top.sv
module pic_seq_top
  import pic_seq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busAddr,
  input  logic              busWrEn,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  input  logic [DATA_W-1:0] reqSet,
  input  logic [DATA_W-1:0] reqClr,
  input  logic [DATA_W-1:0] svcSet,
  output logic              cmdError,
  output logic              initDone,
  output logic [DATA_W-1:0] maskOut,
  output logic [DATA_W-1:0] vecBase,
  output logic [DATA_W-1:0] cascadeCfg,
  output logic [DATA_W-1:0] modeCfg
);

  regStrobe_t strb;
  logic [1:0] word1Mode;

  pic_seq_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .busAddr   (busAddr),
    .busWrEn   (busWrEn),
    .busWrData (busWrData),
    .word1Mode (word1Mode),
    .strb      (strb),
    .ready     (initDone),
    .errPulse  (cmdError)
  );

  pic_seq_regs #(.DATA_W(DATA_W)) u_regs (
    .clk        (clk),
    .rstN       (rstN),
    .busAddr    (busAddr),
    .busWrData  (busWrData),
    .strb       (strb),
    .reqSet     (reqSet),
    .reqClr     (reqClr),
    .svcSet     (svcSet),
    .busRdData  (busRdData),
    .word1Mode  (word1Mode),
    .maskOut    (maskOut),
    .vecBase    (vecBase),
    .cascadeCfg (cascadeCfg),
    .modeCfg    (modeCfg)
  );

endmodule

// File: rtl/pic_seq_checker.sv
module pic_seq_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              busAddr,
  input logic              busWrEn,
  input logic [DATA_W-1:0] busWrData,
  input logic              cmdError,
  input logic              initDone,
  input logic [DATA_W-1:0] maskOut
);

  // R2: an init word 1 always leaves the ready state
  p_init_restart_r2: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && !busAddr && busWrData[4]) |=> !initDone);

  // R3: ready is only ever entered through a write to address 1
  p_ready_entry_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(initDone) |-> $past(busWrEn && busAddr));

  // R4: the mask only moves after a write to address 1
  p_mask_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    !(busWrEn && busAddr) |=> $stable(maskOut));

  // R9: a rejected write changes neither the state nor the mask
  p_reject_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    cmdError |-> ($stable(initDone) && $stable(maskOut)));

  // R11: the error pulse always follows a write
  p_err_cause_r11: assert property (@(posedge clk) disable iff (!rstN)
    cmdError |-> $past(busWrEn && !busAddr));

endmodule

bind pic_seq_top pic_seq_checker #(.DATA_W(DATA_W)) u_checker (
  .clk       (clk),
  .rstN      (rstN),
  .busAddr   (busAddr),
  .busWrEn   (busWrEn),
  .busWrData (busWrData),
  .cmdError  (cmdError),
  .initDone  (initDone),
  .maskOut   (maskOut)
);

// File: tb/test_pic_seq_top.sv
module test_pic_seq_top;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 14;

  typedef struct packed {
    logic       a;
    logic [7:0] d;
    logic       eErr;
    logic       eDone;
    logic [7:0] eRd0;
    logic [7:0] eRd1;
    logic [7:0] eVec;
  } vec_t;

  // Walked from reset: configure, mask, select, reject, reconfigure
  localparam vec_t TBL [NVEC] = '{
    '{1'b0, 8'h11, 1'b0, 1'b0, 8'h00, 8'h00, 8'h00}, // R2 word1 cascaded + word4
    '{1'b1, 8'h20, 1'b0, 1'b0, 8'h00, 8'h00, 8'h20}, // R3 word2 -> wait3
    '{1'b1, 8'h04, 1'b0, 1'b0, 8'h00, 8'h00, 8'h20}, // R3 word3 -> wait4
    '{1'b1, 8'h01, 1'b0, 1'b1, 8'h00, 8'h00, 8'h20}, // R3 word4 -> ready
    '{1'b1, 8'hA5, 1'b0, 1'b1, 8'h00, 8'hA5, 8'h20}, // R4 mask in ready
    '{1'b0, 8'h0B, 1'b0, 1'b1, 8'h00, 8'hA5, 8'h20}, // R5 select in-service
    '{1'b0, 8'h00, 1'b1, 1'b1, 8'h00, 8'hA5, 8'h20}, // R9 bad command code 000
    '{1'b0, 8'hA0, 1'b1, 1'b1, 8'h00, 8'hA5, 8'h20}, // R9 bad command code 101
    '{1'b0, 8'h13, 1'b0, 1'b0, 8'h00, 8'hA5, 8'h20}, // R2 word1 single + word4
    '{1'b1, 8'h40, 1'b0, 1'b0, 8'h00, 8'hA5, 8'h40}, // R3 word2 -> wait4, R4 mask kept
    '{1'b0, 8'h08, 1'b1, 1'b0, 8'h00, 8'hA5, 8'h40}, // R9 command while waiting
    '{1'b1, 8'h00, 1'b0, 1'b1, 8'h00, 8'hA5, 8'h40}, // R3 word4 -> ready
    '{1'b0, 8'h12, 1'b0, 1'b0, 8'h00, 8'hA5, 8'h40}, // R2 word1 single, no word4
    '{1'b1, 8'h68, 1'b0, 1'b1, 8'h00, 8'hA5, 8'h68}  // R3 word2 -> ready
  };

  logic       clk = 1'b0;
  logic       rstN;
  logic       busAddr, busWrEn;
  logic [7:0] busWrData, busRdData;
  logic [7:0] reqSet, reqClr, svcSet;
  logic       cmdError, initDone;
  logic [7:0] maskOut, vecBase, cascadeCfg, modeCfg;

  int checks = 0;
  int failures = 0;
  logic [7:0] rdv;

  always #(CLK_PERIOD/2) clk = ~clk;

  pic_seq_top i_pic_seq_top (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .reqSet(reqSet),
    .reqClr(reqClr), .svcSet(svcSet), .cmdError(cmdError),
    .initDone(initDone), .maskOut(maskOut), .vecBase(vecBase),
    .cascadeCfg(cascadeCfg), .modeCfg(modeCfg)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d, input logic [7:0] svc);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1; svcSet = svc;
    @(negedge clk);
    busWrEn = 1'b0; svcSet = '0;
  endtask

  task automatic rd(input logic a, output logic [7:0] v);
    busAddr = a;
    #1;
    v = busRdData;
  endtask

  task automatic stat(input logic [7:0] s, input logic [7:0] c, input logic [7:0] v);
    @(negedge clk);
    reqSet = s; reqClr = c; svcSet = v;
    @(negedge clk);
    reqSet = '0; reqClr = '0; svcSet = '0;
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rstN = 1'b0; busAddr = 1'b0; busWrEn = 1'b0; busWrData = '0;
    reqSet = '0; reqClr = '0; svcSet = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    chk("R1 initDone", {7'b0, initDone}, 8'h00);
    chk("R1 cmdError", {7'b0, cmdError}, 8'h00);
    rd(1'b0, rdv); chk("R1 rd0", rdv, 8'h00);
    rd(1'b1, rdv); chk("R1 rd1", rdv, 8'h00);
    chk("R1 vecBase", vecBase, 8'h00);

    for (int i = 0; i < NVEC; i++) begin
      wr(TBL[i].a, TBL[i].d, 8'h00);
      chk("R9/R11 table err", {7'b0, cmdError}, {7'b0, TBL[i].eErr});
      chk("R2/R3 table done", {7'b0, initDone}, {7'b0, TBL[i].eDone});
      chk("R3 table vecBase", vecBase, TBL[i].eVec);
      rd(1'b0, rdv); chk("R5 table rd0", rdv, TBL[i].eRd0);
      rd(1'b1, rdv); chk("R4 table rd1", rdv, TBL[i].eRd1);
    end
    chk("R3 cascadeCfg", cascadeCfg, 8'h04);
    chk("R3 modeCfg", modeCfg, 8'h00);

    // R11: pulse lasts one cycle
    @(negedge clk);
    chk("R11 pulse gone", {7'b0, cmdError}, 8'h00);

    // In-service handling (select is still in-service from the table)
    stat(8'h00, 8'h00, 8'h94);
    rd(1'b0, rdv); chk("R10 isr set", rdv, 8'h94);
    wr(1'b0, 8'h20, 8'h00);
    rd(1'b0, rdv); chk("R7 lowest eoi", rdv, 8'h90);
    wr(1'b0, 8'h67, 8'h00);
    rd(1'b0, rdv); chk("R6 level eoi", rdv, 8'h10);
    wr(1'b0, 8'h44, 8'h00);
    chk("R8 noop err", {7'b0, cmdError}, 8'h00);
    rd(1'b0, rdv); chk("R8 noop isr", rdv, 8'h10);
    wr(1'b0, 8'hC4, 8'h00);
    chk("R8 prio err", {7'b0, cmdError}, 8'h00);
    rd(1'b0, rdv); chk("R8 prio isr", rdv, 8'h10);
    wr(1'b0, 8'hE4, 8'h00);
    chk("R9 code 111 err", {7'b0, cmdError}, 8'h01);
    rd(1'b0, rdv); chk("R9 code 111 isr", rdv, 8'h10);

    // Same cycle: retire bit 4 while marking bit 0, then collide on bit 0
    wr(1'b0, 8'h64, 8'h01);
    rd(1'b0, rdv); chk("R10 eoi+set other", rdv, 8'h01);
    wr(1'b0, 8'h60, 8'h01);
    rd(1'b0, rdv); chk("R10 eoi+set same", rdv, 8'h01);
    wr(1'b0, 8'h20, 8'h00);
    rd(1'b0, rdv); chk("R7 last bit", rdv, 8'h00);
    wr(1'b0, 8'h20, 8'h00);
    chk("R7 empty err", {7'b0, cmdError}, 8'h00);
    rd(1'b0, rdv); chk("R7 empty isr", rdv, 8'h00);

    // Request register and read select
    wr(1'b0, 8'h0A, 8'h00);
    stat(8'h3C, 8'h00, 8'h00);
    rd(1'b0, rdv); chk("R5 irr select", rdv, 8'h3C);
    stat(8'h01, 8'h04, 8'h00);
    rd(1'b0, rdv); chk("R10 irr set+clr", rdv, 8'h39);
    stat(8'h02, 8'h02, 8'h00);
    rd(1'b0, rdv); chk("R10 irr collide", rdv, 8'h3B);
    wr(1'b0, 8'h08, 8'h00);
    rd(1'b0, rdv); chk("R5 select 00", rdv, 8'h00);
    wr(1'b0, 8'h09, 8'h00);
    rd(1'b0, rdv); chk("R5 select 01", rdv, 8'h00);

    // R1 reset mid-run
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    chk("R1 done after reset", {7'b0, initDone}, 8'h00);
    rd(1'b0, rdv); chk("R1 irr after reset", rdv, 8'h00);
    rd(1'b1, rdv); chk("R1 mask after reset", rdv, 8'h00);
    chk("R1 vec after reset", vecBase, 8'h00);

    // R4 mask in idle, R9 command in idle
    wr(1'b1, 8'h3C, 8'h00);
    rd(1'b1, rdv); chk("R4 mask idle", rdv, 8'h3C);
    wr(1'b0, 8'h05, 8'h00);
    chk("R9 idle err", {7'b0, cmdError}, 8'h01);
    rd(1'b1, rdv); chk("R9 idle mask", rdv, 8'h3C);
    chk("R9 idle done", {7'b0, initDone}, 8'h00);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule